// File: doc/BRIEF.md
# Reset Source Supervisor

This block sequences the chip-level reset. Two asynchronous digital inputs feed it: a power-on detector (low while the supply is still coming up) and a supply comparator (high while the supply is above the reset threshold). Three synchronous request inputs carry the other reset causes: watchdog, software and external pin. The block drives an active-low reset pin and an active-high core-reset output. Both assert asynchronously and are released synchronously. After the supply becomes good, a counter stretches the reset for a programmable number of cycles.

The block also keeps a 5-bit status word that software reads to learn why the core last came out of reset. It holds a monitor-enable bit that software writes. That bit arms the supply comparator as a reset source. The power-on path clears it, and no other reset touches it. The core restarts from the same place after every reset. The block records only the cause.

Status bit map: bit 0 = pin, bit 1 = power-on, bit 2 = supply monitor, bit 3 = watchdog, bit 4 = software.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n_async` is low, or while `vdd_ok_async` is low during a power-up, `core_rst` is 1. It stays 1 for as long as either condition lasts.
- R2: During a power-up, `core_rst` falls at the (POR_DELAY+2)-th rising clock edge after both `por_n_async` and `vdd_ok_async` are high. If `vdd_ok_async` drops during the count, the count restarts, and the release comes POR_DELAY+2 edges after the supply is good again.
- R3: On release from a power-on reset, `rst_src` reads 5'b00010. Only bit 1 is set, and the other cause bits read 0.
- R4: On release from any other reset, `rst_src` holds exactly one cause bit and bit 1 is 0. If several requests arrive on the same edge, the priority is watchdog (bit 3) over software (bit 4) over pin (bit 0). `rst_src` changes only at the moment of release.
- R5: A request (`wdt_req`, `sw_req` or `pin_req`) sampled high at a rising edge while the core runs sets `core_rst` after that edge. `core_rst` is released HOLD_CYCLES edges later, provided `pin_req` is low and the supply is good.
- R6: With `mon_en` at 1, a low `vdd_ok_async` sets `core_rst` at once, without waiting for a clock. The reset holds while the supply is low and is released at the (HOLD_CYCLES+2)-th edge after the supply returns. `rst_src` then reads 5'b00100.
- R7: With `mon_en` at 0, a low `vdd_ok_async` while the core runs has no effect: `core_rst` stays 0 and `rst_src` is unchanged.
- R8: `mon_en` is 0 after a power-on reset. A write (`mon_we`) updates it only while `core_rst` is 0. Watchdog, software, pin and monitor resets leave it unchanged.
- R9: `rst_pin_n` is always the inverse of `core_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| por_n_async | input | 1 | Power-on detector, low while power is not established (asynchronous) |
| vdd_ok_async | input | 1 | Supply comparator, high when supply is above the reset threshold (asynchronous) |
| wdt_req | input | 1 | Watchdog reset request |
| sw_req | input | 1 | Software reset request |
| pin_req | input | 1 | External pin reset request; a held level extends the reset |
| mon_we | input | 1 | Write strobe for the monitor-enable bit |
| mon_wdata | input | 1 | Value written to the monitor-enable bit |
| rst_pin_n | output | 1 | Active-low reset pin drive |
| core_rst | output | 1 | Active-high core reset |
| rst_src | output | 5 | Reset-cause status word |
| mon_en | output | 1 | Current monitor-enable state |

## Verification
A request sampled at edge 1 is visible on `core_rst` right after that edge and is released after edge 1+HOLD_CYCLES. A power-up release or supply return passes through the two synchronizer flops, so it is due after edge POR_DELAY+2 or HOLD_CYCLES+2. Monitor assertion is combinational and is checked one time unit after the supply drops. The bench drives inputs at falling edges and samples at falling edges. At each release it checks that reset is still present after the edge just before the due edge, and absent after the due edge. In the same cycle as the release it reads `rst_src` and `mon_en`.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int POR_DELAY   = 16,
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por_n_async,
  input  logic       vdd_ok_async,
  input  logic       wdt_req,
  input  logic       sw_req,
  input  logic       pin_req,
  input  logic       mon_we,
  input  logic       mon_wdata,
  output logic       rst_pin_n,
  output logic       core_rst,
  output logic [4:0] rst_src,
  output logic       mon_en
);

  localparam int MAXC = (POR_DELAY > HOLD_CYCLES) ? POR_DELAY : HOLD_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] POR_TERM  = CW'(POR_DELAY - 1);
  localparam logic [CW-1:0] HOLD_TERM = CW'(HOLD_CYCLES - 1);

  localparam logic [4:0] SRC_PIN = 5'b00001;
  localparam logic [4:0] SRC_POR = 5'b00010;
  localparam logic [4:0] SRC_MON = 5'b00100;
  localparam logic [4:0] SRC_WDT = 5'b01000;
  localparam logic [4:0] SRC_SW  = 5'b10000;

  initial begin
    if (POR_DELAY < 1 || HOLD_CYCLES < 1)
      $error("rst_supervisor: delays must be at least 1");
  end

  logic          por_m, por_s, vdd_m, vdd_s;
  logic          in_reset, por_pend;
  logic [4:0]    cause, req_cause;
  logic [CW-1:0] cnt, term;
  logic          mon_trip, hold, req_any;

  always_ff @(posedge clk or negedge por_n_async)
    if (!por_n_async) begin
      por_m <= 1'b0;
      por_s <= 1'b0;
      vdd_m <= 1'b0;
      vdd_s <= 1'b0;
    end else begin
      por_m <= 1'b1;
      por_s <= por_m;
      vdd_m <= vdd_ok_async;
      vdd_s <= vdd_m;
    end

  assign mon_trip  = mon_en & ~vdd_ok_async;
  assign hold      = ~por_s | ~vdd_s | pin_req;
  assign term      = por_pend ? POR_TERM : HOLD_TERM;
  assign req_any   = wdt_req | sw_req | pin_req;
  assign req_cause = wdt_req ? SRC_WDT : (sw_req ? SRC_SW : SRC_PIN);

  always_ff @(posedge clk or negedge por_n_async or posedge mon_trip)
    if (!por_n_async) begin
      in_reset <= 1'b1;
      por_pend <= 1'b1;
      cause    <= SRC_POR;
      cnt      <= '0;
      rst_src  <= SRC_POR;
    end else if (mon_trip) begin
      in_reset <= 1'b1;
      cause    <= SRC_MON;
      cnt      <= '0;
    end else if (in_reset) begin
      if (hold) begin
        cnt <= '0;
      end else if (cnt == term) begin
        in_reset <= 1'b0;
        por_pend <= 1'b0;
        cnt      <= '0;
        rst_src  <= por_pend ? SRC_POR : cause;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (req_any) begin
      in_reset <= 1'b1;
      cause    <= req_cause;
      cnt      <= '0;
    end

  always_ff @(posedge clk or negedge por_n_async)
    if (!por_n_async)
      mon_en <= 1'b0;
    else if (mon_we && !in_reset)
      mon_en <= mon_wdata;

  assign core_rst  = in_reset | ~por_n_async | mon_trip;
  assign rst_pin_n = ~core_rst;

  p_src_onehot_r4: assert property (@(posedge clk) disable iff (!por_n_async)
    $countones(rst_src) == 1);

  p_src_stable_r4: assert property (@(posedge clk) disable iff (!por_n_async)
    (!in_reset && $past(!in_reset)) |-> $stable(rst_src));

  p_por_flag_r3: assert property (@(posedge clk) disable iff (!por_n_async)
    ($fell(in_reset) && $past(por_pend)) |-> (rst_src == SRC_POR));

  p_req_enter_r5: assert property (@(posedge clk) disable iff (!por_n_async)
    (!core_rst && req_any) |=> core_rst);

  p_mon_keep_r8: assert property (@(posedge clk) disable iff (!por_n_async)
    !mon_we |=> $stable(mon_en));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!por_n_async)
    (!mon_en && !mon_we && !in_reset && !req_any) |=> !in_reset);

endmodule

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;

  localparam int D = 12;
  localparam int H = 5;

  logic clk = 1'b0;
  logic por_n_async, vdd_ok_async, wdt_req, sw_req, pin_req, mon_we, mon_wdata;
  logic rst_pin_n, core_rst, mon_en;
  logic [4:0] rst_src;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  rst_supervisor #(.POR_DELAY(D), .HOLD_CYCLES(H)) dut_i (
    .clk(clk), .por_n_async(por_n_async), .vdd_ok_async(vdd_ok_async),
    .wdt_req(wdt_req), .sw_req(sw_req), .pin_req(pin_req),
    .mon_we(mon_we), .mon_wdata(mon_wdata),
    .rst_pin_n(rst_pin_n), .core_rst(core_rst), .rst_src(rst_src), .mon_en(mon_en)
  );

  // {wdt, sw, pin, expected rst_src}
  localparam logic [7:0] VEC [0:5] = '{
    8'b100_01000, 8'b010_10000, 8'b001_00001,
    8'b110_01000, 8'b011_10000, 8'b111_01000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mon(input logic v);
    mon_we = 1'b1; mon_wdata = v;
    @(negedge clk);
    mon_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    por_n_async = 1'b0; vdd_ok_async = 1'b0;
    wdt_req = 1'b0; sw_req = 1'b0; pin_req = 1'b0; mon_we = 1'b0; mon_wdata = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset while power-on low", core_rst, 1);
    check("R9 pin low in reset", rst_pin_n, 0);

    por_n_async = 1'b1;
    repeat (30) @(negedge clk);
    check("R1 held while supply low", core_rst, 1);

    vdd_ok_async = 1'b1;
    wait_edges(1 + D);
    check("R2 still in reset before delay end", core_rst, 1);
    wait_edges(1);
    check("R2 released after delay", core_rst, 0);
    check("R3 power-on flag only", rst_src, 5'b00010);
    check("R8 monitor off after power-on", mon_en, 0);
    check("R9 pin high when released", rst_pin_n, 1);

    for (int i = 0; i < 6; i++) begin
      {wdt_req, sw_req, pin_req} = VEC[i][7:5];
      @(posedge clk);
      @(negedge clk);
      {wdt_req, sw_req, pin_req} = 3'b000;
      check($sformatf("R5 entry vec%0d", i), core_rst, 1);
      wait_edges(H - 1);
      check($sformatf("R5 hold vec%0d", i), core_rst, 1);
      wait_edges(1);
      check($sformatf("R5 release vec%0d", i), core_rst, 0);
      check($sformatf("R4 cause vec%0d", i), rst_src, {27'd0, VEC[i][4:0]});
      repeat (2) @(negedge clk);
    end

    write_mon(1'b1);
    check("R8 write while running", mon_en, 1);

    wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
    write_mon(1'b0);
    wait_edges(H + 2);
    check("R8 write ignored in reset", mon_en, 1);
    check("R4 watchdog cause", rst_src, 5'b01000);

    vdd_ok_async = 1'b0;
    #1;
    check("R6 immediate monitor reset", core_rst, 1);
    repeat (6) @(negedge clk);
    check("R6 held while supply low", core_rst, 1);
    vdd_ok_async = 1'b1;
    wait_edges(1 + H);
    check("R6 still in reset", core_rst, 0 + 1);
    wait_edges(1);
    check("R6 released", core_rst, 0);
    check("R6 monitor cause", rst_src, 5'b00100);
    check("R8 enable kept after monitor reset", mon_en, 1);

    write_mon(1'b0);
    vdd_ok_async = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check($sformatf("R7 ignored drop cycle%0d", k), core_rst, 0);
    end
    vdd_ok_async = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 status unchanged", rst_src, 5'b00100);

    write_mon(1'b1);
    por_n_async = 1'b0;
    #1;
    check("R1 immediate power-on reset", core_rst, 1);
    @(negedge clk);
    por_n_async = 1'b1;
    repeat (5) @(negedge clk);
    vdd_ok_async = 1'b0;
    @(negedge clk);
    vdd_ok_async = 1'b1;
    wait_edges(1 + D);
    check("R2 reload keeps reset", core_rst, 1);
    wait_edges(1);
    check("R2 release after reload", core_rst, 0);
    check("R3 power-on flag again", rst_src, 5'b00010);
    check("R8 power-on clears enable", mon_en, 0);

    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    wait_edges(H + 1);
    check("R4 power-on flag cleared by software reset", rst_src, 5'b10000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule